// File: doc/BRIEF.md
# Core Test Wrapper Serial Unit

This unit surrounds an embedded core with a serial test wrapper that is steered entirely by dedicated enable lines on the wrapper clock. There is no sequencing state machine. A select line picks one of two scan paths. When it is high, the scan path runs through an instruction register. When it is low, it runs through the data register that the current instruction names. Capture, shift and update enables act on the rising clock edge. The serial output is retimed on the falling edge.

The boundary register holds one cell per core input and one cell per core output. Every cell has four connections: a functional input, a functional output, a serial test input and a serial test output. Each cell has two storage elements: a shift-path element and an off-path update element. The decoded instruction decides what the core and the surrounding logic see:
- the normal functional values;
- the update elements, to drive patterns;
- fixed safe values set by parameters.

Top module: `core_wrap_serial`

## Requirements
- R1: While rst_ni is low, and after it rises, the instruction is bypass (code 0). In bypass, `core_in_o` equals `func_in_i`, `func_out_o` equals `core_out_i`, and `wso_o` is 0.
- R2: The instruction register is 3 bits wide and shifts least significant bit first. A capture with `sel_ir_i` high loads 3'b001 into it. A new code takes effect only on an update with `sel_ir_i` high. The codes are: bypass 0, external test 1, internal test 2, preload 3, clamp 4, safe 5.
- R3: The bypass path is a single flop. A capture clears it, so a scan reads 0 first and then each input bit one cycle late. `wso_o` changes only on the falling edge of `wrck_i`.
- R4: The boundary register has bit positions 0 to NUM_IN-1 for the input cells and NUM_IN to NUM_IN+NUM_OUT-1 for the output cells. It shifts from `wsi_i` toward bit 0, and bit 0 drives `wso_o`. Under external test (1), a capture loads `{core_out_i, func_in_i}`, and `func_out_o` shows the update elements of the output cells.
- R5: Under internal test (2), `core_in_o` shows the update elements of the input cells, and `func_out_o` stays equal to `core_out_i`.
- R6: Under preload (3), the boundary register shifts and updates, but both functional outputs stay in their functional values.
- R7: Under clamp (4), `func_out_o` holds the output-cell update values from earlier scans, and the scan path is the bypass flop.
- R8: Under safe (5), `core_in_o` equals SAFE_IN, `func_out_o` equals SAFE_OUT, and the scan path is the bypass flop.
- R9: The update elements change only on an update event. Shifting and capturing without an update leave the outputs that are driven from the update elements unchanged.
- R10: Codes 6 and 7 behave exactly like bypass.
- R11: A low level on rst_ni forces the functional outputs back to their functional values at once, without a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrck_i | input | 1 | Wrapper clock |
| rst_ni | input | 1 | Asynchronous active-low wrapper reset |
| sel_ir_i | input | 1 | High selects the instruction path, low selects the data path |
| capture_i | input | 1 | Capture enable |
| shift_i | input | 1 | Shift enable |
| update_i | input | 1 | Update enable |
| wsi_i | input | 1 | Serial scan input |
| wso_o | output | 1 | Serial scan output, retimed on the falling edge |
| func_in_i | input | NUM_IN | Functional values arriving for the core inputs |
| core_in_o | output | NUM_IN | Values delivered to the core inputs |
| core_out_i | input | NUM_OUT | Values produced by the core outputs |
| func_out_o | output | NUM_OUT | Values delivered to the logic around the core |

## Verification
If the decoded instruction is wrong, the functional outputs take the wrong source as soon as the update edge has passed. The serial path length also changes, so the very next scan returns 1 bit in place of NUM_IN+NUM_OUT bits, or the reverse. A corrupted cell shift element shows on `wso_o` at the falling edge of the scan cycle that reaches that cell's position. A corrupted update element shows immediately on the driven output under external test, internal test or clamp. Bypass and reset faults show in the first bit that a scan reads back.

// File: rtl/wrap_pkg.sv
`timescale 1ns/1ps
package wrap_pkg;
  localparam int IR_W = 3;

  typedef enum logic [IR_W-1:0] {
    I_BYPASS  = 3'd0,
    I_EXTEST  = 3'd1,
    I_INTEST  = 3'd2,
    I_PRELOAD = 3'd3,
    I_CLAMP   = 3'd4,
    I_SAFE    = 3'd5
  } instr_e;

  function automatic logic uses_bsr(logic [IR_W-1:0] code);
    return (code == I_EXTEST) || (code == I_INTEST) || (code == I_PRELOAD);
  endfunction
endpackage

// File: rtl/wrap_ir.sv
`timescale 1ns/1ps
module wrap_ir
  import wrap_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            sel_i,
  input  logic            capture_i,
  input  logic            shift_i,
  input  logic            update_i,
  input  logic            si_i,
  output logic            so_o,
  output logic [IR_W-1:0] instr_o
);
  logic [IR_W-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q    <= '0;
      instr_o <= I_BYPASS;
    end else if (sel_i) begin
      if (capture_i)    sr_q <= IR_W'(1);
      else if (shift_i) sr_q <= {si_i, sr_q[IR_W-1:1]};
      if (update_i)     instr_o <= sr_q;
    end
  end

  assign so_o = sr_q[0];
endmodule

// File: rtl/wrap_bypass.sv
`timescale 1ns/1ps
module wrap_bypass (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic capture_i,
  input  logic shift_i,
  input  logic si_i,
  output logic so_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   so_o <= 1'b0;
    else if (en_i && capture_i)    so_o <= 1'b0;
    else if (en_i && shift_i)      so_o <= si_i;
  end
endmodule

// File: rtl/wrap_cell.sv
`timescale 1ns/1ps
module wrap_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cap_en_i,
  input  logic shift_en_i,
  input  logic upd_en_i,
  input  logic cfi_i,
  input  logic si_i,
  output logic sr_o,
  output logic up_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_o <= 1'b0;
      up_o <= 1'b0;
    end else begin
      if (cap_en_i)        sr_o <= cfi_i;
      else if (shift_en_i) sr_o <= si_i;
      if (upd_en_i)        up_o <= sr_o;
    end
  end
endmodule

// File: rtl/core_wrap_serial.sv
`timescale 1ns/1ps
module core_wrap_serial
  import wrap_pkg::*;
#(
  parameter int                 NUM_IN   = 4,
  parameter int                 NUM_OUT  = 4,
  parameter logic [NUM_IN-1:0]  SAFE_IN  = '0,
  parameter logic [NUM_OUT-1:0] SAFE_OUT = '0
) (
  input  logic               wrck_i,
  input  logic               rst_ni,
  input  logic               sel_ir_i,
  input  logic               capture_i,
  input  logic               shift_i,
  input  logic               update_i,
  input  logic               wsi_i,
  output logic               wso_o,
  input  logic [NUM_IN-1:0]  func_in_i,
  output logic [NUM_IN-1:0]  core_in_o,
  input  logic [NUM_OUT-1:0] core_out_i,
  output logic [NUM_OUT-1:0] func_out_o
);
  localparam int TOT = NUM_IN + NUM_OUT;

  logic [IR_W-1:0] instr_q;
  logic            ir_so, byp_so, bsr_sel, dr_bsr;
  logic [TOT-1:0]  cfi, sr, up, si;

  assign bsr_sel = uses_bsr(instr_q);
  assign dr_bsr  = !sel_ir_i && bsr_sel;
  assign cfi     = {core_out_i, func_in_i};

  wrap_ir u_ir (
    .clk_i(wrck_i), .rst_ni(rst_ni), .sel_i(sel_ir_i),
    .capture_i(capture_i), .shift_i(shift_i), .update_i(update_i),
    .si_i(wsi_i), .so_o(ir_so), .instr_o(instr_q)
  );

  wrap_bypass u_byp (
    .clk_i(wrck_i), .rst_ni(rst_ni), .en_i(!sel_ir_i && !bsr_sel),
    .capture_i(capture_i), .shift_i(shift_i), .si_i(wsi_i), .so_o(byp_so)
  );

  // chain runs from wsi_i at the top bit down to bit 0
  for (genvar k = 0; k < TOT; k++) begin : g_cell
    if (k == TOT - 1) begin : g_head
      assign si[k] = wsi_i;
    end else begin : g_link
      assign si[k] = sr[k+1];
    end
    wrap_cell u_cell (
      .clk_i(wrck_i), .rst_ni(rst_ni),
      .cap_en_i(dr_bsr && capture_i),
      .shift_en_i(dr_bsr && shift_i),
      .upd_en_i(dr_bsr && update_i),
      .cfi_i(cfi[k]), .si_i(si[k]), .sr_o(sr[k]), .up_o(up[k])
    );
  end

  always_comb begin
    core_in_o  = func_in_i;
    func_out_o = core_out_i;
    case (instr_q)
      I_EXTEST: func_out_o = up[TOT-1:NUM_IN];
      I_INTEST: core_in_o  = up[NUM_IN-1:0];
      I_CLAMP:  func_out_o = up[TOT-1:NUM_IN];
      I_SAFE: begin
        core_in_o  = SAFE_IN;
        func_out_o = SAFE_OUT;
      end
      default: ;
    endcase
  end

  always_ff @(negedge wrck_i or negedge rst_ni) begin
    if (!rst_ni)       wso_o <= 1'b0;
    else if (sel_ir_i) wso_o <= ir_so;
    else if (bsr_sel)  wso_o <= sr[0];
    else               wso_o <= byp_so;
  end
endmodule

// File: rtl/wrap_chk.sv
`timescale 1ns/1ps
module wrap_chk
  import wrap_pkg::*;
#(
  parameter int                 NUM_IN   = 4,
  parameter int                 NUM_OUT  = 4,
  parameter logic [NUM_IN-1:0]  SAFE_IN  = '0,
  parameter logic [NUM_OUT-1:0] SAFE_OUT = '0
) (
  input logic               wrck_i,
  input logic               rst_ni,
  input logic               sel_ir_i,
  input logic               shift_i,
  input logic               update_i,
  input logic               wsi_i,
  input logic               byp_so,
  input logic [IR_W-1:0]    instr_q,
  input logic [NUM_IN-1:0]  func_in_i,
  input logic [NUM_IN-1:0]  core_in_o,
  input logic [NUM_OUT-1:0] core_out_i,
  input logic [NUM_OUT-1:0] func_out_o
);
  p_bypass_func_r1: assert property (@(posedge wrck_i) disable iff (!rst_ni)
    (instr_q == I_BYPASS) |-> (func_out_o == core_out_i && core_in_o == func_in_i));

  p_ir_hold_r2: assert property (@(posedge wrck_i) disable iff (!rst_ni)
    !(sel_ir_i && update_i) |=> $stable(instr_q));

  p_byp_delay_r3: assert property (@(posedge wrck_i) disable iff (!rst_ni)
    (!sel_ir_i && shift_i && !uses_bsr(instr_q)) |=> (byp_so == $past(wsi_i)));

  p_preload_func_r6: assert property (@(posedge wrck_i) disable iff (!rst_ni)
    (instr_q == I_PRELOAD) |-> (func_out_o == core_out_i && core_in_o == func_in_i));

  p_clamp_hold_r7: assert property (@(posedge wrck_i) disable iff (!rst_ni)
    (instr_q == I_CLAMP) |=> (instr_q != I_CLAMP || $stable(func_out_o)));

  p_safe_vals_r8: assert property (@(posedge wrck_i) disable iff (!rst_ni)
    (instr_q == I_SAFE) |-> (func_out_o == SAFE_OUT && core_in_o == SAFE_IN));

  p_unknown_r10: assert property (@(posedge wrck_i) disable iff (!rst_ni)
    (instr_q > I_SAFE) |-> (func_out_o == core_out_i && core_in_o == func_in_i));
endmodule

bind core_wrap_serial wrap_chk #(
  .NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT), .SAFE_IN(SAFE_IN), .SAFE_OUT(SAFE_OUT)
) u_chk (
  .wrck_i(wrck_i), .rst_ni(rst_ni), .sel_ir_i(sel_ir_i), .shift_i(shift_i),
  .update_i(update_i), .wsi_i(wsi_i), .byp_so(byp_so), .instr_q(instr_q),
  .func_in_i(func_in_i), .core_in_o(core_in_o),
  .core_out_i(core_out_i), .func_out_o(func_out_o)
);

// File: tb/tb_core_wrap_serial.sv
`timescale 1ns/1ps
module tb_core_wrap_serial;
  localparam int NI = 4;
  localparam int NO = 4;
  localparam int TOT = NI + NO;
  localparam logic [NI-1:0] S_IN  = 4'b1001;
  localparam logic [NO-1:0] S_OUT = 4'b0110;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic sel_ir = 1'b0, capture = 1'b0, shift = 1'b0, update = 1'b0, wsi = 1'b0;
  logic wso;
  logic [NI-1:0] func_in = '0, core_in;
  logic [NO-1:0] core_out = '0, func_out;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  core_wrap_serial #(.NUM_IN(NI), .NUM_OUT(NO), .SAFE_IN(S_IN), .SAFE_OUT(S_OUT)) dut (
    .wrck_i(clk), .rst_ni(rst_ni), .sel_ir_i(sel_ir), .capture_i(capture),
    .shift_i(shift), .update_i(update), .wsi_i(wsi), .wso_o(wso),
    .func_in_i(func_in), .core_in_o(core_in), .core_out_i(core_out), .func_out_o(func_out)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic ir_scan(input logic [2:0] code, output logic [2:0] cap);
    sel_ir = 1'b1; capture = 1'b1;
    @(posedge clk); #1; capture = 1'b0; shift = 1'b1;
    for (int k = 0; k < 3; k++) begin
      wsi = code[k];
      @(negedge clk); #1; cap[k] = wso;
      @(posedge clk); #1;
    end
    shift = 1'b0; update = 1'b1;
    @(posedge clk); #1; update = 1'b0; sel_ir = 1'b0;
  endtask

  task automatic dr_scan(input logic [TOT-1:0] din, input bit do_upd, output logic [TOT-1:0] dout);
    sel_ir = 1'b0; capture = 1'b1;
    @(posedge clk); #1; capture = 1'b0; shift = 1'b1;
    for (int k = 0; k < TOT; k++) begin
      wsi = din[k];
      @(negedge clk); #1; dout[k] = wso;
      @(posedge clk); #1;
    end
    shift = 1'b0;
    if (do_upd) begin
      update = 1'b1;
      @(posedge clk); #1; update = 1'b0;
    end
  endtask

  task automatic t_reset;
    core_out = 4'b0011; func_in = 4'b1100; #1;
    chk("R1 func_out in reset", func_out, 4'b0011);
    chk("R1 core_in in reset", core_in, 4'b1100);
    chk("R1 wso in reset", wso, 0);
    rst_ni = 1'b1;
    @(posedge clk); #1;
    chk("R1 func_out after reset", func_out, 4'b0011);
  endtask

  task automatic t_ir;
    logic [2:0] cap;
    ir_scan(3'd1, cap);
    chk("R2 ir capture pattern", cap, 3'b001);
    chk("R2 extest active after update", func_out, 4'b0000);
    ir_scan(3'd0, cap);
    chk("R2 bypass restored", func_out, core_out);
  endtask

  task automatic t_bypass;
    logic [TOT-1:0] d, q;
    logic a;
    d = 8'b0011_0110;
    dr_scan(d, 1'b0, q);
    chk("R3 bypass one-bit delay", q, {d[TOT-2:0], 1'b0});
    sel_ir = 1'b0; wsi = 1'b1; shift = 1'b1;
    @(negedge clk); #1; a = wso;
    @(posedge clk); #1;
    chk("R3 wso stable at rising edge", wso, a);
    shift = 1'b0;
    @(negedge clk); #1;
    chk("R3 wso moves at falling edge", wso, 1);
    @(posedge clk); #1;
  endtask

  task automatic t_extest;
    logic [2:0] cap;
    logic [TOT-1:0] q;
    ir_scan(3'd1, cap);
    func_in = 4'b1100; core_out = 4'b0011;
    dr_scan(8'b1010_0101, 1'b1, q);
    chk("R4 extest capture", q, 8'b0011_1100);
    chk("R4 extest drives func_out", func_out, 4'b1010);
    chk("R4 extest core_in functional", core_in, 4'b1100);
  endtask

  task automatic t_hold;
    logic [TOT-1:0] q;
    dr_scan(8'b0101_1111, 1'b0, q);
    chk("R9 no update keeps func_out", func_out, 4'b1010);
    update = 1'b1;
    @(posedge clk); #1; update = 1'b0;
    chk("R9 update applies shifted data", func_out, 4'b0101);
  endtask

  task automatic t_intest;
    logic [2:0] cap;
    logic [TOT-1:0] q;
    core_out = 4'b1001; func_in = 4'b0100;
    ir_scan(3'd2, cap);
    chk("R5 intest uses held update", core_in, 4'b1111);
    dr_scan(8'b0110_0011, 1'b1, q);
    chk("R5 intest capture", q, 8'b1001_0100);
    chk("R5 intest drives core_in", core_in, 4'b0011);
    chk("R5 intest func_out functional", func_out, 4'b1001);
  endtask

  task automatic t_preload;
    logic [2:0] cap;
    logic [TOT-1:0] q;
    core_out = 4'b0110; func_in = 4'b1010;
    ir_scan(3'd3, cap);
    dr_scan(8'b1100_0000, 1'b1, q);
    chk("R6 preload func_out functional", func_out, 4'b0110);
    chk("R6 preload core_in functional", core_in, 4'b1010);
  endtask

  task automatic t_clamp;
    logic [2:0] cap;
    logic [TOT-1:0] d, q;
    ir_scan(3'd4, cap);
    chk("R7 clamp drives preloaded", func_out, 4'b1100);
    chk("R7 clamp core_in functional", core_in, 4'b1010);
    d = 8'b1110_0010;
    dr_scan(d, 1'b1, q);
    chk("R7 clamp serial via bypass", q, {d[TOT-2:0], 1'b0});
    chk("R7 clamp value held", func_out, 4'b1100);
  endtask

  task automatic t_safe;
    logic [2:0] cap;
    logic [TOT-1:0] d, q;
    ir_scan(3'd5, cap);
    chk("R8 safe func_out", func_out, S_OUT);
    chk("R8 safe core_in", core_in, S_IN);
    d = 8'b0100_1101;
    dr_scan(d, 1'b1, q);
    chk("R8 safe serial via bypass", q, {d[TOT-2:0], 1'b0});
  endtask

  task automatic t_unknown;
    logic [2:0] cap;
    logic [TOT-1:0] d, q;
    ir_scan(3'd7, cap);
    chk("R10 code 7 func_out", func_out, core_out);
    chk("R10 code 7 core_in", core_in, func_in);
    d = 8'b1001_0111;
    dr_scan(d, 1'b1, q);
    chk("R10 code 7 bypass path", q, {d[TOT-2:0], 1'b0});
    ir_scan(3'd6, cap);
    chk("R10 code 6 func_out", func_out, core_out);
  endtask

  task automatic t_async;
    logic [2:0] cap;
    ir_scan(3'd1, cap);
    chk("R11 extest before reset", func_out, 4'b1100);
    #0.7 rst_ni = 1'b0;
    #0.3;
    chk("R11 async reset func_out", func_out, core_out);
    chk("R11 async reset wso", wso, 0);
    #10 rst_ni = 1'b1;
    @(posedge clk); #1;
    chk("R11 stays functional after release", func_out, core_out);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #12;
    t_reset;
    t_ir;
    t_bypass;
    t_extest;
    t_hold;
    t_intest;
    t_preload;
    t_clamp;
    t_safe;
    t_unknown;
    t_async;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule